// File: doc/BRIEF.md
# 2D Blit Command Stream Parser

This block sits between a command queue and a 2D drawing engine. It takes 32-bit command words on a valid/ready input. Each packet begins with a header word, and the top nibble of that header gives the packet kind. Some packets are complete in their header. Others are followed by a fixed or header-dependent number of payload words. The parser keeps a set of persistent drawing-state registers: clip rectangle, pattern placement, colour-key and alpha control, source and mask offsets, four surface descriptors and two palette addresses. Each packet kind updates its own part of that state.

A blit packet is the only kind that produces work. Whether its fill-colour word is present depends on a select bit in the blit header itself. When the last payload word of a blit is taken, the parser raises a descriptor valid flag. The descriptor outputs then show the blit's own fields together with all state latched by earlier packets. The descriptor is held until the consumer accepts it, and the input stalls meanwhile.

Fence and flush headers produce one-cycle event pulses. A reserved packet kind sets a sticky error flag. After that, the parser drops words until a flush header brings it back into step.

Top module: `blit_cmd_parser`

## Requirements
- R1: Header bits 31:28 select the packet kind, with these payload word counts:
  - kind 0 (clip): 2 words;
  - kind 2 (control): two words for each of header bits 0 and 1 that is set, plus one word if bit 2 is set;
  - kind 8 (blit): 3 words if header bit 16 is 0, 2 words if it is 1;
  - kinds 9, A, B and E (surfaces): 2 words;
  - every other kind: no payload.
- R2: A blit header's bits 26:0 appear on `blt_mode`. When bit 16 of the blit header is 1 (pattern), no fill word follows and `blt_fill` reads zero.
- R3: Blit payload words arrive in this order:
  - the fill colour (present only when header bit 16 is 0);
  - the destination start, with X in bits 23:12 and Y in bits 11:0;
  - the size, with width in bits 23:12 and height in bits 11:0.

  `blt_valid` rises in the cycle after the last blit word is accepted.
- R4: While `blt_valid` is high, `cmd_ready` is low and every descriptor output is held. `blt_valid` falls in the cycle after a cycle in which `blt_ready` is high.
- R5: The first clip payload word gives X max (bits 23:12) and X min (bits 11:0). The second gives Y max (bits 23:12) and Y min (bits 11:0).
- R6: Control header bits 2:0 appear on `blt_ctl_flags`, where bit 0 is source key present, bit 1 is destination key present and bit 2 is alpha present. The words that follow are, in this order and each only if its group is present: source key colour, source key mask, destination key colour, destination key mask, alpha word. A group that is absent keeps its previous value.
- R7: These header fields are latched with no payload:
  - pattern header bits 19:0 to `blt_pat_ctl`;
  - source offset header bits 23:0 to `blt_src_off`;
  - mask offset header bits 23:0 to `blt_msk_off`.
- R8: Surface packets are kind 9 (source), A (destination), B (pattern) and E (mask).
  - Payload word 0 holds the pixel format in bits 18:15 and the stride in bits 14:0.
  - Payload word 1 holds the 4-byte-aligned base address in bits 27:2.
  - Each surface output is packed as {address[25:0], format[3:0], stride[14:0]}.
- R9: Palette headers of kind C (source) and D (pattern) latch header bits 27:3 to `blt_src_pal` and `blt_pat_pal`.
- R10: A fence header (kind 7) pulses `fence_evt` high for one cycle, in the cycle after it is accepted. Header bits 27:0 have no effect.
- R11: A flush header (kind F) pulses `flush_evt` high for one cycle, in the cycle after it is accepted.
- R12: A header of kind 5 or 6 sets `dec_err` in the next cycle. While `dec_err` is set:
  - every word is accepted and discarded, leaving all outputs unchanged and raising no blit;
  - the first word with bits 31:28 equal to F clears `dec_err` and pulses `flush_evt`.
- R13: After reset, all state outputs, `blt_valid`, the event pulses and `dec_err` are zero, and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Parser accepts a word this cycle |
| cmd_data | input | 32 | Command word |
| blt_valid | output | 1 | Blit descriptor available |
| blt_ready | input | 1 | Consumer takes the descriptor |
| blt_mode | output | 27 | Blit header bits 26:0 (ROPs, selects, modes) |
| blt_fill | output | 32 | Fill colour |
| blt_dst_x | output | COORD_W | Destination X start |
| blt_dst_y | output | COORD_W | Destination Y start |
| blt_width | output | COORD_W | Blit width |
| blt_height | output | COORD_W | Blit height |
| blt_clip_xmin | output | COORD_W | Clip X min |
| blt_clip_xmax | output | COORD_W | Clip X max |
| blt_clip_ymin | output | COORD_W | Clip Y min |
| blt_clip_ymax | output | COORD_W | Clip Y max |
| blt_ctl_flags | output | 3 | Control present flags |
| blt_src_key | output | 32 | Source key colour |
| blt_src_kmask | output | 32 | Source key mask |
| blt_dst_key | output | 32 | Destination key colour |
| blt_dst_kmask | output | 32 | Destination key mask |
| blt_alpha | output | 32 | Alpha control word |
| blt_pat_ctl | output | 20 | Pattern placement fields |
| blt_src_off | output | 2*COORD_W | Source offset |
| blt_msk_off | output | 2*COORD_W | Mask offset |
| blt_src_surf | output | 45 | Source surface descriptor |
| blt_dst_surf | output | 45 | Destination surface descriptor |
| blt_pat_surf | output | 45 | Pattern surface descriptor |
| blt_msk_surf | output | 45 | Mask surface descriptor |
| blt_src_pal | output | 25 | Source palette address |
| blt_pat_pal | output | 25 | Pattern palette address |
| fence_evt | output | 1 | Fence pulse |
| flush_evt | output | 1 | Flush pulse |
| dec_err | output | 1 | Sticky reserved-kind error |

## Verification
The bench builds the parser with its default coordinate width of 12. At that width the 23:12 and 11:0 field positions of the command format are exact, so every coordinate word and offset header can be written as a literal of the real format. The control stimulus covers several present-flag combinations, including the case where only one group is present, so that the per-slot steering and the keep-old behaviour are both exercised. The blit stimulus covers both fill and pattern select with the consumer stalled, and the error stimulus feeds blit, clip and surface headers while words are being dropped.

// File: rtl/blit_pkg.sv
// Package: shared constants and the packet-kind encoding of the blit parser.
// Assumes 32-bit command words and the fixed surface field layout.
package blit_pkg;
    localparam int WORD_W       = 32;
    localparam int BODY_W       = 28;   // header bits below the kind nibble
    localparam int SLOT_N       = 5;    // most payload words any packet carries
    localparam int SLOT_W       = $clog2(SLOT_N);
    localparam int MODE_W       = 27;
    localparam int FILL_SEL_BIT = 16;
    localparam int CFLAG_W      = 3;
    localparam int PATCTL_W     = 20;
    localparam int FMT_W        = 4;
    localparam int STRIDE_W     = 15;
    localparam int ADDR_W       = 26;
    localparam int ADDR_LSB     = 2;
    localparam int SURF_W       = ADDR_W + FMT_W + STRIDE_W;
    localparam int PAL_LSB      = 3;
    localparam int PAL_W        = BODY_W - PAL_LSB;
    localparam int NSURF        = 4;

    typedef enum logic [3:0] {
        PK_CLIP    = 4'h0, PK_PAT     = 4'h1, PK_CTRL    = 4'h2, PK_SRCOFF  = 4'h3,
        PK_MSKOFF  = 4'h4, PK_RSV5    = 4'h5, PK_RSV6    = 4'h6, PK_FENCE   = 4'h7,
        PK_BLIT    = 4'h8, PK_SRCSURF = 4'h9, PK_DSTSURF = 4'hA, PK_PATSURF = 4'hB,
        PK_SRCPAL  = 4'hC, PK_PATPAL  = 4'hD, PK_MSKSURF = 4'hE, PK_FLUSH   = 4'hF
    } pkt_kind_e;

    // Maps a surface register index to the packet kind that writes it.
    function automatic pkt_kind_e surf_kind(input int idx);
        case (idx)
            0:       return PK_SRCSURF;
            1:       return PK_DSTSURF;
            2:       return PK_PATSURF;
            default: return PK_MSKSURF;
        endcase
    endfunction
endpackage

// File: rtl/blit_hdr_decode.sv
// Header decoder: classifies a header nibble and gives the set of payload
// slots that will follow it. Purely combinational; assumes the caller only
// uses the result while a header is expected.
module blit_hdr_decode
    import blit_pkg::*;
(
    input  logic [3:0]          hdr_type,
    input  logic                fill_sel,
    input  logic [CFLAG_W-1:0]  ctl_present,
    output pkt_kind_e           kind,
    output logic [SLOT_N-1:0]   slots,
    output logic                reserved
);
    // Slot map per kind; a set bit means one payload word with that role.
    always_comb begin
        kind     = pkt_kind_e'(hdr_type);
        slots    = '0;
        reserved = 1'b0;
        case (kind)
            PK_CLIP, PK_SRCSURF, PK_DSTSURF, PK_PATSURF, PK_MSKSURF:
                slots = SLOT_N'(5'b00011);
            PK_CTRL:
                slots = SLOT_N'({ctl_present[2], ctl_present[1], ctl_present[1],
                                 ctl_present[0], ctl_present[0]});
            PK_BLIT:
                slots = fill_sel ? SLOT_N'(5'b00110) : SLOT_N'(5'b00111);
            PK_RSV5, PK_RSV6:
                reserved = 1'b1;
            default: slots = '0;
        endcase
    end
endmodule

// File: rtl/blit_seq.sv
// Packet sequencer: tracks header/payload/discard phase, steps through the
// pending payload slots lowest first, raises the blit valid flag and the
// fence, flush and error outputs. Assumes blt_ready may arrive any cycle.
module blit_seq
    import blit_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [3:0]          cmd_type,
    input  pkt_kind_e           dec_kind,
    input  logic [SLOT_N-1:0]   dec_slots,
    input  logic                dec_rsv,
    input  logic                blt_ready,
    output logic                cmd_ready,
    output logic                hdr_take,
    output logic                pay_take,
    output pkt_kind_e           pay_kind,
    output logic [SLOT_W-1:0]   pay_slot,
    output logic                blt_valid,
    output logic                fence_evt,
    output logic                flush_evt,
    output logic                dec_err
);
    typedef enum logic [1:0] {ST_HDR, ST_PAY, ST_DROP} phase_e;

    phase_e             st_q;
    logic [SLOT_N-1:0]  pend_q;
    logic [SLOT_N-1:0]  low_one;
    logic [SLOT_N-1:0]  pend_next;
    pkt_kind_e          kind_q;
    logic               bv_q, fence_q, flush_q, err_q;
    logic               accept;

    // Input handshake: stall only while a descriptor waits.
    assign cmd_ready = !bv_q;
    assign accept    = cmd_valid && cmd_ready;
    assign hdr_take  = accept && (st_q == ST_HDR);
    assign pay_take  = accept && (st_q == ST_PAY);
    assign pay_kind  = kind_q;

    // Lowest pending slot is the role of the next payload word.
    always_comb begin
        pay_slot = '0;
        for (int i = SLOT_N - 1; i >= 0; i--) begin
            if (pend_q[i]) pay_slot = SLOT_W'(i);
        end
    end

    assign low_one   = pend_q & (~pend_q + SLOT_N'(1));
    assign pend_next = pend_q & ~low_one;

    // Phase, slot tracking, descriptor flag and event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_HDR;
            pend_q  <= '0;
            kind_q  <= PK_CLIP;
            bv_q    <= 1'b0;
            fence_q <= 1'b0;
            flush_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            fence_q <= hdr_take && (dec_kind == PK_FENCE);
            flush_q <= (hdr_take && (dec_kind == PK_FLUSH)) ||
                       (accept && (st_q == ST_DROP) && (cmd_type == PK_FLUSH));
            if (bv_q && blt_ready) bv_q <= 1'b0;
            case (st_q)
                ST_HDR: begin
                    if (hdr_take) begin
                        if (dec_rsv) begin
                            err_q <= 1'b1;
                            st_q  <= ST_DROP;
                        end else if (|dec_slots) begin
                            st_q   <= ST_PAY;
                            pend_q <= dec_slots;
                            kind_q <= dec_kind;
                        end
                    end
                end
                ST_PAY: begin
                    if (pay_take) begin
                        pend_q <= pend_next;
                        if (pend_next == '0) begin
                            st_q <= ST_HDR;
                            if (kind_q == PK_BLIT) bv_q <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (accept && (cmd_type == PK_FLUSH)) begin
                        err_q <= 1'b0;
                        st_q  <= ST_HDR;
                    end
                end
            endcase
        end
    end

    assign blt_valid = bv_q;
    assign fence_evt = fence_q;
    assign flush_evt = flush_q;
    assign dec_err   = err_q;
endmodule

// File: rtl/blit_state_regs.sv
// Drawing-state registers: header fields are written on hdr_take, payload
// words on pay_take steered by packet kind and slot. All clear on reset.
// Assumes the sequencer never asserts both strobes in one cycle.
module blit_state_regs
    import blit_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hdr_take,
    input  pkt_kind_e            hdr_kind,
    input  logic [BODY_W-1:0]    hdr_body,
    input  logic                 pay_take,
    input  pkt_kind_e            pay_kind,
    input  logic [SLOT_W-1:0]    pay_slot,
    input  logic [WORD_W-1:0]    pay_word,
    output logic [MODE_W-1:0]    mode,
    output logic [WORD_W-1:0]    fill,
    output logic [COORD_W-1:0]   dst_x,
    output logic [COORD_W-1:0]   dst_y,
    output logic [COORD_W-1:0]   width,
    output logic [COORD_W-1:0]   height,
    output logic [COORD_W-1:0]   clip_xmin,
    output logic [COORD_W-1:0]   clip_xmax,
    output logic [COORD_W-1:0]   clip_ymin,
    output logic [COORD_W-1:0]   clip_ymax,
    output logic [CFLAG_W-1:0]   ctl_flags,
    output logic [WORD_W-1:0]    ctl_word [SLOT_N],
    output logic [PATCTL_W-1:0]  pat_ctl,
    output logic [2*COORD_W-1:0] src_off,
    output logic [2*COORD_W-1:0] msk_off,
    output logic [SURF_W-1:0]    surf [NSURF],
    output logic [PAL_W-1:0]     src_pal,
    output logic [PAL_W-1:0]     pat_pal
);
    localparam int PAIR_W = 2 * COORD_W;

    logic [PAIR_W-1:0] dxy_q, size_q, clipx_q, clipy_q;

    // Blit header fields and the fill word (cleared for pattern blits).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
            fill <= '0;
        end else if (hdr_take && hdr_kind == PK_BLIT) begin
            mode <= hdr_body[MODE_W-1:0];
            if (hdr_body[FILL_SEL_BIT]) fill <= '0;
        end else if (pay_take && pay_kind == PK_BLIT && pay_slot == SLOT_W'(0)) begin
            fill <= pay_word;
        end
    end

    // Blit destination start and size words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dxy_q  <= '0;
            size_q <= '0;
        end else if (pay_take && pay_kind == PK_BLIT) begin
            if (pay_slot == SLOT_W'(1)) dxy_q  <= pay_word[PAIR_W-1:0];
            if (pay_slot == SLOT_W'(2)) size_q <= pay_word[PAIR_W-1:0];
        end
    end

    // Clip rectangle words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clipx_q <= '0;
            clipy_q <= '0;
        end else if (pay_take && pay_kind == PK_CLIP) begin
            if (pay_slot == SLOT_W'(0)) clipx_q <= pay_word[PAIR_W-1:0];
            if (pay_slot == SLOT_W'(1)) clipy_q <= pay_word[PAIR_W-1:0];
        end
    end

    // Header-only fields: pattern placement, offsets, control flags, palettes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_ctl   <= '0;
            src_off   <= '0;
            msk_off   <= '0;
            ctl_flags <= '0;
            src_pal   <= '0;
            pat_pal   <= '0;
        end else if (hdr_take) begin
            case (hdr_kind)
                PK_PAT:    pat_ctl   <= hdr_body[PATCTL_W-1:0];
                PK_SRCOFF: src_off   <= hdr_body[PAIR_W-1:0];
                PK_MSKOFF: msk_off   <= hdr_body[PAIR_W-1:0];
                PK_CTRL:   ctl_flags <= hdr_body[CFLAG_W-1:0];
                PK_SRCPAL: src_pal   <= hdr_body[BODY_W-1:PAL_LSB];
                PK_PATPAL: pat_pal   <= hdr_body[BODY_W-1:PAL_LSB];
                default: ;
            endcase
        end
    end

    // One register per control slot: key colours, key masks, alpha word.
    for (genvar g = 0; g < SLOT_N; g++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (!rst_n) ctl_word[g] <= '0;
            else if (pay_take && pay_kind == PK_CTRL && pay_slot == SLOT_W'(g))
                ctl_word[g] <= pay_word;
        end
    end

    // One descriptor per surface kind; word 0 format/stride, word 1 address.
    for (genvar s = 0; s < NSURF; s++) begin : g_surf
        localparam pkt_kind_e KS = surf_kind(s);
        always_ff @(posedge clk) begin
            if (!rst_n) surf[s] <= '0;
            else if (pay_take && pay_kind == KS) begin
                if (pay_slot == SLOT_W'(0))
                    surf[s][FMT_W+STRIDE_W-1:0] <= pay_word[FMT_W+STRIDE_W-1:0];
                if (pay_slot == SLOT_W'(1))
                    surf[s][SURF_W-1 -: ADDR_W] <= pay_word[ADDR_W+ADDR_LSB-1:ADDR_LSB];
            end
        end
    end

    assign dst_x     = dxy_q[PAIR_W-1:COORD_W];
    assign dst_y     = dxy_q[COORD_W-1:0];
    assign width     = size_q[PAIR_W-1:COORD_W];
    assign height    = size_q[COORD_W-1:0];
    assign clip_xmax = clipx_q[PAIR_W-1:COORD_W];
    assign clip_xmin = clipx_q[COORD_W-1:0];
    assign clip_ymax = clipy_q[PAIR_W-1:COORD_W];
    assign clip_ymin = clipy_q[COORD_W-1:0];
endmodule

// File: rtl/blit_cmd_parser.sv
// Top: 2D blit command stream parser. Decodes headers, collects payload
// words into persistent drawing state and presents one descriptor per blit
// packet. Assumes a single command source and a single descriptor consumer.
module blit_cmd_parser
    import blit_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [31:0]          cmd_data,
    output logic                 blt_valid,
    input  logic                 blt_ready,
    output logic [26:0]          blt_mode,
    output logic [31:0]          blt_fill,
    output logic [COORD_W-1:0]   blt_dst_x,
    output logic [COORD_W-1:0]   blt_dst_y,
    output logic [COORD_W-1:0]   blt_width,
    output logic [COORD_W-1:0]   blt_height,
    output logic [COORD_W-1:0]   blt_clip_xmin,
    output logic [COORD_W-1:0]   blt_clip_xmax,
    output logic [COORD_W-1:0]   blt_clip_ymin,
    output logic [COORD_W-1:0]   blt_clip_ymax,
    output logic [2:0]           blt_ctl_flags,
    output logic [31:0]          blt_src_key,
    output logic [31:0]          blt_src_kmask,
    output logic [31:0]          blt_dst_key,
    output logic [31:0]          blt_dst_kmask,
    output logic [31:0]          blt_alpha,
    output logic [19:0]          blt_pat_ctl,
    output logic [2*COORD_W-1:0] blt_src_off,
    output logic [2*COORD_W-1:0] blt_msk_off,
    output logic [44:0]          blt_src_surf,
    output logic [44:0]          blt_dst_surf,
    output logic [44:0]          blt_pat_surf,
    output logic [44:0]          blt_msk_surf,
    output logic [24:0]          blt_src_pal,
    output logic [24:0]          blt_pat_pal,
    output logic                 fence_evt,
    output logic                 flush_evt,
    output logic                 dec_err
);
    pkt_kind_e          dec_kind, pay_kind;
    logic [SLOT_N-1:0]  dec_slots;
    logic               dec_rsv, hdr_take, pay_take;
    logic [SLOT_W-1:0]  pay_slot;
    logic [WORD_W-1:0]  ctl_word [SLOT_N];
    logic [SURF_W-1:0]  surf [NSURF];

    blit_hdr_decode u_dec (
        .hdr_type    (cmd_data[31:28]),
        .fill_sel    (cmd_data[FILL_SEL_BIT]),
        .ctl_present (cmd_data[CFLAG_W-1:0]),
        .kind        (dec_kind),
        .slots       (dec_slots),
        .reserved    (dec_rsv)
    );

    blit_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_type  (cmd_data[31:28]),
        .dec_kind  (dec_kind),
        .dec_slots (dec_slots),
        .dec_rsv   (dec_rsv),
        .blt_ready (blt_ready),
        .cmd_ready (cmd_ready),
        .hdr_take  (hdr_take),
        .pay_take  (pay_take),
        .pay_kind  (pay_kind),
        .pay_slot  (pay_slot),
        .blt_valid (blt_valid),
        .fence_evt (fence_evt),
        .flush_evt (flush_evt),
        .dec_err   (dec_err)
    );

    blit_state_regs #(.COORD_W(COORD_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_take  (hdr_take),
        .hdr_kind  (dec_kind),
        .hdr_body  (cmd_data[BODY_W-1:0]),
        .pay_take  (pay_take),
        .pay_kind  (pay_kind),
        .pay_slot  (pay_slot),
        .pay_word  (cmd_data),
        .mode      (blt_mode),
        .fill      (blt_fill),
        .dst_x     (blt_dst_x),
        .dst_y     (blt_dst_y),
        .width     (blt_width),
        .height    (blt_height),
        .clip_xmin (blt_clip_xmin),
        .clip_xmax (blt_clip_xmax),
        .clip_ymin (blt_clip_ymin),
        .clip_ymax (blt_clip_ymax),
        .ctl_flags (blt_ctl_flags),
        .ctl_word  (ctl_word),
        .pat_ctl   (blt_pat_ctl),
        .src_off   (blt_src_off),
        .msk_off   (blt_msk_off),
        .surf      (surf),
        .src_pal   (blt_src_pal),
        .pat_pal   (blt_pat_pal)
    );

    assign blt_src_key   = ctl_word[0];
    assign blt_src_kmask = ctl_word[1];
    assign blt_dst_key   = ctl_word[2];
    assign blt_dst_kmask = ctl_word[3];
    assign blt_alpha     = ctl_word[4];
    assign blt_src_surf  = surf[0];
    assign blt_dst_surf  = surf[1];
    assign blt_pat_surf  = surf[2];
    assign blt_msk_surf  = surf[3];
endmodule

// File: rtl/blit_cmd_parser_chk.sv
// Checker: temporal properties of the parser's handshake, events and error
// flag, observed at the top-level ports. Bound into every parser instance.
module blit_cmd_parser_chk #(
    parameter int COORD_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic [3:0]         cmd_type,
    input logic               blt_valid,
    input logic               blt_ready,
    input logic [26:0]        blt_mode,
    input logic [31:0]        blt_fill,
    input logic [COORD_W-1:0] blt_dst_x,
    input logic [COORD_W-1:0] blt_width,
    input logic               fence_evt,
    input logic               flush_evt,
    input logic               dec_err
);
    // R4: no input is taken while a descriptor waits
    a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
        blt_valid |-> !cmd_ready);

    // R4: an unaccepted descriptor stays valid and unchanged
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (blt_valid && !blt_ready) |=> (blt_valid && $stable(blt_mode) &&
            $stable(blt_fill) && $stable(blt_dst_x) && $stable(blt_width)));

    // R3: a descriptor appears only after an accepted word
    a_r3_valid_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blt_valid) |-> $past(cmd_valid && cmd_ready));

    // R10: fence pulse follows an accepted fence header
    a_r10_fence_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fence_evt |-> ($past(cmd_valid && cmd_ready) && $past(cmd_type) == 4'h7));

    // R11: flush pulse follows an accepted flush word
    a_r11_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
        flush_evt |-> ($past(cmd_valid && cmd_ready) && $past(cmd_type) == 4'hF));

    // R12: error is set only by a reserved kind
    a_r12_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_err) |-> ($past(cmd_valid && cmd_ready) &&
            ($past(cmd_type) == 4'h5 || $past(cmd_type) == 4'h6)));

    // R12: no descriptor while words are being dropped
    a_r12_err_no_blit: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> !blt_valid);

    // R12: error clears only on a flush word
    a_r12_err_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dec_err) |-> flush_evt);
endmodule

bind blit_cmd_parser blit_cmd_parser_chk #(.COORD_W(COORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_type  (cmd_data[31:28]),
    .blt_valid (blt_valid),
    .blt_ready (blt_ready),
    .blt_mode  (blt_mode),
    .blt_fill  (blt_fill),
    .blt_dst_x (blt_dst_x),
    .blt_width (blt_width),
    .fence_evt (fence_evt),
    .flush_evt (flush_evt),
    .dec_err   (dec_err)
);

// File: tb/blit_cmd_parser_tb.sv
// Bench: behavioural reference model (role queue, plain variables) updated
// on each edge, compared against every output each cycle.
module blit_cmd_parser_tb;
    localparam int CW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [31:0] cmd_data = '0;
    logic blt_ready = 1'b0;

    logic cmd_ready, blt_valid, fence_evt, flush_evt, dec_err;
    logic [26:0] blt_mode;
    logic [31:0] blt_fill, blt_src_key, blt_src_kmask, blt_dst_key, blt_dst_kmask, blt_alpha;
    logic [CW-1:0] blt_dst_x, blt_dst_y, blt_width, blt_height;
    logic [CW-1:0] blt_clip_xmin, blt_clip_xmax, blt_clip_ymin, blt_clip_ymax;
    logic [2:0] blt_ctl_flags;
    logic [19:0] blt_pat_ctl;
    logic [2*CW-1:0] blt_src_off, blt_msk_off;
    logic [44:0] blt_src_surf, blt_dst_surf, blt_pat_surf, blt_msk_surf;
    logic [24:0] blt_src_pal, blt_pat_pal;

    always #4 clk = ~clk;   // 125 MHz

    blit_cmd_parser #(.COORD_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .blt_valid(blt_valid), .blt_ready(blt_ready),
        .blt_mode(blt_mode), .blt_fill(blt_fill), .blt_dst_x(blt_dst_x),
        .blt_dst_y(blt_dst_y), .blt_width(blt_width), .blt_height(blt_height),
        .blt_clip_xmin(blt_clip_xmin), .blt_clip_xmax(blt_clip_xmax),
        .blt_clip_ymin(blt_clip_ymin), .blt_clip_ymax(blt_clip_ymax),
        .blt_ctl_flags(blt_ctl_flags), .blt_src_key(blt_src_key),
        .blt_src_kmask(blt_src_kmask), .blt_dst_key(blt_dst_key),
        .blt_dst_kmask(blt_dst_kmask), .blt_alpha(blt_alpha),
        .blt_pat_ctl(blt_pat_ctl), .blt_src_off(blt_src_off),
        .blt_msk_off(blt_msk_off), .blt_src_surf(blt_src_surf),
        .blt_dst_surf(blt_dst_surf), .blt_pat_surf(blt_pat_surf),
        .blt_msk_surf(blt_msk_surf), .blt_src_pal(blt_src_pal),
        .blt_pat_pal(blt_pat_pal), .fence_evt(fence_evt),
        .flush_evt(flush_evt), .dec_err(dec_err)
    );

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    // ---------------- reference model ----------------
    bit m_bv, m_fence, m_flush, m_err;
    int roles[$];
    logic [26:0] e_mode;
    logic [31:0] e_fill;
    logic [31:0] e_ck [5];
    logic [CW-1:0] e_dx, e_dy, e_w, e_h, e_cx0, e_cx1, e_cy0, e_cy1;
    logic [2:0] e_cf;
    logic [19:0] e_pat;
    logic [2*CW-1:0] e_soff, e_moff;
    logic [44:0] e_surf [4];
    logic [24:0] e_spal, e_ppal;

    task automatic model_reset();
        m_bv = 0; m_fence = 0; m_flush = 0; m_err = 0; roles.delete();
        e_mode = '0; e_fill = '0; e_dx = '0; e_dy = '0; e_w = '0; e_h = '0;
        e_cx0 = '0; e_cx1 = '0; e_cy0 = '0; e_cy1 = '0; e_cf = '0; e_pat = '0;
        e_soff = '0; e_moff = '0; e_spal = '0; e_ppal = '0;
        for (int i = 0; i < 5; i++) e_ck[i] = '0;
        for (int i = 0; i < 4; i++) e_surf[i] = '0;
    endtask

    task automatic model_word(input logic [31:0] w);
        int r, s;
        if (m_err) begin
            if (w[31:28] == 4'hF) begin m_err = 0; m_flush = 1; end
        end else if (roles.size() > 0) begin
            r = roles.pop_front();
            if (r == 0) e_fill = w;
            else if (r == 1) begin e_dx = w[23:12]; e_dy = w[11:0]; end
            else if (r == 2) begin e_w = w[23:12]; e_h = w[11:0]; end
            else if (r == 10) begin e_cx1 = w[23:12]; e_cx0 = w[11:0]; end
            else if (r == 11) begin e_cy1 = w[23:12]; e_cy0 = w[11:0]; end
            else if (r >= 20 && r < 25) e_ck[r-20] = w;
            else begin
                s = (r - 30) / 2;
                if ((r - 30) % 2 == 0) e_surf[s][18:0] = w[18:0];
                else e_surf[s][44:19] = w[27:2];
            end
            if (roles.size() == 0 && r <= 2) m_bv = 1;
        end else begin
            case (w[31:28])
                4'h0: begin roles.push_back(10); roles.push_back(11); end
                4'h1: e_pat = w[19:0];
                4'h2: begin
                    e_cf = w[2:0];
                    if (w[0]) begin roles.push_back(20); roles.push_back(21); end
                    if (w[1]) begin roles.push_back(22); roles.push_back(23); end
                    if (w[2]) roles.push_back(24);
                end
                4'h3: e_soff = w[23:0];
                4'h4: e_moff = w[23:0];
                4'h5, 4'h6: m_err = 1;
                4'h7: m_fence = 1;
                4'h8: begin
                    e_mode = w[26:0];
                    if (w[16]) e_fill = '0; else roles.push_back(0);
                    roles.push_back(1); roles.push_back(2);
                end
                4'h9, 4'hA, 4'hB, 4'hE: begin
                    s = (w[31:28] == 4'h9) ? 0 : (w[31:28] == 4'hA) ? 1 :
                        (w[31:28] == 4'hB) ? 2 : 3;
                    roles.push_back(30 + 2*s); roles.push_back(31 + 2*s);
                end
                4'hC: e_spal = w[27:3];
                4'hD: e_ppal = w[27:3];
                default: m_flush = 1;
            endcase
        end
    endtask

    // Model advance on each edge, from bench-driven inputs only.
    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            bit acc;
            acc = cmd_valid && !m_bv;
            m_fence = 0; m_flush = 0;
            if (m_bv && blt_ready) m_bv = 0;
            if (acc) model_word(cmd_data);
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output 2 ns after each edge.
    always begin
        @(posedge clk);
        #2;
        if (cmp_on) begin
            chk("R4 cmd_ready", 64'(cmd_ready), 64'(!m_bv));
            chk("R1 R3 blt_valid", 64'(blt_valid), 64'(m_bv));
            chk("R10 fence_evt", 64'(fence_evt), 64'(m_fence));
            chk("R11 flush_evt", 64'(flush_evt), 64'(m_flush));
            chk("R12 dec_err", 64'(dec_err), 64'(m_err));
            chk("R2 blt_mode", 64'(blt_mode), 64'(e_mode));
            chk("R2 blt_fill", 64'(blt_fill), 64'(e_fill));
            chk("R3 dst_x", 64'(blt_dst_x), 64'(e_dx));
            chk("R3 dst_y", 64'(blt_dst_y), 64'(e_dy));
            chk("R3 width", 64'(blt_width), 64'(e_w));
            chk("R3 height", 64'(blt_height), 64'(e_h));
            chk("R5 clip x", 64'({blt_clip_xmax, blt_clip_xmin}), 64'({e_cx1, e_cx0}));
            chk("R5 clip y", 64'({blt_clip_ymax, blt_clip_ymin}), 64'({e_cy1, e_cy0}));
            chk("R6 flags", 64'(blt_ctl_flags), 64'(e_cf));
            chk("R6 src key", {blt_src_key, blt_src_kmask}, {e_ck[0], e_ck[1]});
            chk("R6 dst key", {blt_dst_key, blt_dst_kmask}, {e_ck[2], e_ck[3]});
            chk("R6 alpha", 64'(blt_alpha), 64'(e_ck[4]));
            chk("R7 pat_ctl", 64'(blt_pat_ctl), 64'(e_pat));
            chk("R7 offsets", {16'h0, blt_src_off, blt_msk_off}, {16'h0, e_soff, e_moff});
            chk("R8 src surf", 64'(blt_src_surf), 64'(e_surf[0]));
            chk("R8 dst surf", 64'(blt_dst_surf), 64'(e_surf[1]));
            chk("R8 pat surf", 64'(blt_pat_surf), 64'(e_surf[2]));
            chk("R8 msk surf", 64'(blt_msk_surf), 64'(e_surf[3]));
            chk("R9 palettes", 64'({blt_src_pal, blt_pat_pal}), 64'({e_spal, e_ppal}));
        end
    end

    // Drive one word starting at a falling edge; return once it is taken.
    task automatic send(input logic [31:0] w);
        cmd_valid = 1'b1;
        cmd_data  = w;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        cmd_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        // R13: reset state at the ports
        chk("R13 reset ready", 64'(cmd_ready), 64'd1);
        chk("R13 reset surf", 64'(blt_dst_surf), 64'd0);
        chk("R13 reset err", 64'(dec_err), 64'd0);

        // R5 clip, R7 pattern and offsets
        send(32'h0012_3045); send(32'hFF12_3045); send(32'h0067_8009);
        send(32'h100A_BCDE); send(32'h3AB1_2345); send(32'h4055_6677);
        // R6 control: all groups, then destination only
        send(32'h2000_0007);
        send(32'h1111_1111); send(32'h2222_2222); send(32'h3333_3333);
        send(32'h4444_4444); send(32'h5555_5555);
        send(32'h2000_0002); send(32'hAAAA_0001); send(32'hBBBB_0002);
        send(32'h2000_0004); send(32'h0C0C_0C0C);
        send(32'h2000_0000);
        // R8 surfaces, R9 palettes
        send(32'h9000_0000); send(32'h0006_0400); send(32'hF123_4567);
        send(32'hA000_0000); send(32'hFFFF_FFFF); send(32'h0876_5438);
        send(32'hB000_0000); send(32'h0000_7FFF); send(32'h0000_0004);
        send(32'hE000_0000); send(32'h0004_8010); send(32'h0FFF_FFFC);
        send(32'hC123_4567); send(32'hDFED_CBA8);

        // R2 R3 R4: fill blit with consumer stalled
        blt_ready = 1'b0;
        send(32'h86AE_CCCC); send(32'hDEAD_BEEF); send(32'h0010_0020); send(32'h0040_0008);
        cmd_valid = 1'b1; cmd_data = 32'h7000_0000;  // waits behind descriptor
        repeat (5) @(negedge clk);
        chk("R4 stalled blit", 64'(blt_valid), 64'd1);
        blt_ready = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        // R2: pattern blit, no fill word
        send(32'h8001_F0F0); send(32'h0123_0456); send(32'h0789_0ABC);
        idle(2);
        chk("R2 pattern fill zero", 64'(blt_fill), 64'd0);
        // R10 fence with ignored bits, R11 flush
        send(32'h7FFF_FFFF); send(32'hF000_0000); send(32'hF123_4567);
        idle(2);

        // R12: reserved kind then dropped words
        send(32'h5000_0000);
        send(32'h8000_0000); send(32'h0999_0999); send(32'h9000_0000);
        send(32'h1FFF_FFFF); send(32'hC000_0008);
        idle(3);
        chk("R12 no blit while dropping", 64'(blt_valid), 64'd0);
        send(32'hF000_0000);
        send(32'h6000_0001); send(32'h2000_0007); send(32'hF00F_0000);
        // back-to-back blits after recovery
        blt_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            send({4'h8, 11'h0, k[0], 16'h00CC});
            if (!k[0]) send(32'hCAFE_0000 + k);
            send(32'h0001_0001 + k); send(32'h0002_0003);
        end
        idle(4);
        chk("R12 error cleared", 64'(dec_err), 64'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule